// File: doc/BRIEF.md
# Serial Configuration Loader for a Programmable Logic Target

This block brings up a programmable logic device through its bit-serial configuration port. It owns three output pins (a program line, a configuration clock and a serial data line) and watches two status pins from the target (init and done). One pulse on the start input runs a complete load. First the block pulses the program line and takes the target through its reset handshake. It then shifts a bit stream, supplied one bit at a time over a valid/ready interface, onto the data pin. Finally it waits for the target to report completion.

Each of the three waits in the handshake has its own timeout. A wait is measured in poll intervals, and the interval is a parameter counted in system clock cycles. The result of a run is a success flag or a 2-bit error code. Both stay readable after the run until the next start. Every serial bit uses a fixed four-step pin pattern, so the target sees setup and hold margins on both sides of each rising clock edge. The length of each step is a parameter. The block does not parse or decompress the image. Whatever supplies the bits has already done that work.

Top module: `cfg_serial_loader`

## Requirements
- R1: While idle and out of reset, the program line is at its inactive level, the configuration clock and data pins are high, `busy_o` is low and `bit_ready_o` is low.
- R2: A start pulse while idle asserts the program line and the block waits for the synchronised init input to read low. If init stays high for the whole timeout, the block returns to idle with error code 1.
- R3: Once init reads low, the program line is released and the block waits for init to read high. If init stays low for the whole timeout, the block returns to idle with error code 2.
- R4: A wait times out after exactly (POLL_LIMIT+1)*POLL_CYCLES cycles in the wait state. A condition that is met on the last cycle still counts as met.
- R5: Each bit takes four steps of STEP_CYCLES cycles each, in this order: clock low with data high, clock low with data equal to the bit, clock high with data equal to the bit, clock high with data high. Between bits both pins rest high.
- R6: During the shift phase, `bit_ready_o` is high only when no bit is in flight. A bit is taken on a cycle where valid and ready are both high. A bit taken with `bit_last_i` set ends the stream. Valid is ignored outside the shift phase.
- R7: After the last bit, the block waits for the synchronised done input to read high and then reports `done_ok_o`=1 with error code 0. If done stays low for the whole timeout, the block reports error code 3. `done_ok_o` is never high while the error code is nonzero.
- R8: A start that is accepted clears the error code and the success flag. Both then hold their value from the end of the run until the next accepted start. A start pulse while busy is ignored.
- R9: With PROG_ACTIVE_HIGH=0 the program line is driven low when asserted. With PROG_ACTIVE_HIGH=1 it is driven high when asserted.
- R10: The init and done inputs pass through two synchronising flops. A change on the pin affects the outputs on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a load |
| busy_o | output | 1 | High while a load is in progress |
| done_ok_o | output | 1 | Last load finished successfully |
| err_code_o | output | 2 | 0 none, 1 init never fell, 2 init never rose, 3 done never rose |
| bit_valid_i | input | 1 | Stream bit is valid |
| bit_data_i | input | 1 | Stream bit value |
| bit_last_i | input | 1 | This bit is the final bit of the stream |
| bit_ready_o | output | 1 | Block accepts a bit this cycle |
| cfg_prog_o | output | 1 | Program line to the target |
| cfg_clk_o | output | 1 | Configuration clock to the target |
| cfg_data_o | output | 1 | Serial data to the target |
| cfg_init_i | input | 1 | Init status from the target (asynchronous) |
| cfg_done_i | input | 1 | Done status from the target (asynchronous) |

## Verification
The bench runs four loads against a behavioural model and compares every pin on every clock. The first is a successful load with a mixed bit pattern. The source stalls between bits, and a stray start arrives mid-run. This separates correct stepping and handshake pacing from an off-by-one in the step counter or the ready logic. The other three loads each stall the target at a different handshake stage. Each one must produce its own error code after exactly the timeout length, which tells apart the three timeouts and exposes an error in the poll count. A second instance with the opposite program-line polarity runs alongside the first. Explicit probes check the two-flop input latency and the count of clock pulses.

// File: rtl/cfgs_pkg.sv
// Shared types for the serial configuration loader.
// Assumes: nothing beyond IEEE 1800-2017.
package cfgs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PROG      = 3'd1,
        ST_INIT_WAIT = 3'd2,
        ST_SHIFT     = 3'd3,
        ST_DONE_WAIT = 3'd4
    } cfg_state_t;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_INIT_LOW  = 2'd1,
        ERR_INIT_HIGH = 2'd2,
        ERR_DONE      = 2'd3
    } cfg_err_t;

    typedef enum logic [1:0] {
        STEP_CLK_LOW  = 2'd0,
        STEP_SETUP    = 2'd1,
        STEP_CLK_HIGH = 2'd2,
        STEP_RELEASE  = 2'd3
    } bit_step_t;

endpackage

// File: rtl/cfgs_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous status inputs.
// Assumes: each bit is independent (no bus coherency required).
module cfgs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] pipe_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the raw asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[0] <= '0;
                else        pipe_q[0] <= async_i;
            end
        end else begin : g_next
            // Pass the value one stage further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[s] <= '0;
                else        pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cfgs_poll_timer.sv
// Wait-state timer: counts poll intervals of POLL_CYCLES cycles and flags
// expiry on the final cycle of interval number POLL_LIMIT (counted from 0).
// Assumes: clr_i pulses on every state change so each wait starts at zero.
module cfgs_poll_timer #(
    parameter int POLL_CYCLES = 125000,
    parameter int POLL_LIMIT  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic expired_o
);
    localparam int CW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam int PW = (POLL_LIMIT  > 0) ? $clog2(POLL_LIMIT + 1) : 1;
    localparam logic [CW-1:0] CYC_LAST  = CW'(POLL_CYCLES - 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT);

    logic [CW-1:0] cyc_q;
    logic [PW-1:0] poll_q;
    logic          wrap;

    assign wrap      = (cyc_q == CYC_LAST);
    assign expired_o = run_i && wrap && (poll_q == POLL_LAST);

    // Advance the cycle and poll counters while a wait is running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || clr_i) begin
            cyc_q  <= '0;
            poll_q <= '0;
        end else if (wrap) begin
            cyc_q  <= '0;
            if (poll_q != POLL_LAST) poll_q <= poll_q + 1'b1;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfgs_bit_shifter.sv
// Takes one stream bit at a time and plays it on the clock/data pins in
// four equal steps; both pins rest high when no bit is in flight.
// Assumes: en_i is high only during the shift phase; STEP_CYCLES >= 1.
module cfgs_bit_shifter
    import cfgs_pkg::*;
#(
    parameter int STEP_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic bit_valid_i,
    input  logic bit_data_i,
    input  logic bit_last_i,
    output logic bit_ready_o,
    output logic pin_clk_o,
    output logic pin_data_o,
    output logic stream_end_o
);
    localparam int SW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CYCLES - 1);

    logic          active_q;
    bit_step_t     step_q;
    logic [SW-1:0] scnt_q;
    logic          bit_q;
    logic          last_q;
    logic          step_end;
    logic          accept;

    assign bit_ready_o  = en_i && !active_q;
    assign accept       = bit_ready_o && bit_valid_i;
    assign step_end     = active_q && (scnt_q == STEP_LAST);
    assign stream_end_o = step_end && (step_q == STEP_RELEASE) && last_q;

    // Latch an accepted bit and walk it through the four pin steps.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            active_q <= 1'b0;
            step_q   <= STEP_CLK_LOW;
            scnt_q   <= '0;
            bit_q    <= 1'b1;
            last_q   <= 1'b0;
        end else if (accept) begin
            active_q <= 1'b1;
            step_q   <= STEP_CLK_LOW;
            scnt_q   <= '0;
            bit_q    <= bit_data_i;
            last_q   <= bit_last_i;
        end else if (step_end) begin
            scnt_q <= '0;
            if (step_q == STEP_RELEASE) active_q <= 1'b0;
            else                        step_q   <= bit_step_t'(step_q + 2'd1);
        end else if (active_q) begin
            scnt_q <= scnt_q + 1'b1;
        end
    end

    // Decode the pin levels from the current step.
    always_comb begin
        pin_clk_o  = 1'b1;
        pin_data_o = 1'b1;
        if (active_q) begin
            unique case (step_q)
                STEP_CLK_LOW:  begin pin_clk_o = 1'b0; pin_data_o = 1'b1;  end
                STEP_SETUP:    begin pin_clk_o = 1'b0; pin_data_o = bit_q; end
                STEP_CLK_HIGH: begin pin_clk_o = 1'b1; pin_data_o = bit_q; end
                default:       begin pin_clk_o = 1'b1; pin_data_o = 1'b1;  end
            endcase
        end
    end
endmodule

// File: rtl/cfg_serial_loader.sv
// Top of the serial configuration loader: sequences program pulse,
// init fall, init rise, bit shifting and done wait, with one timeout
// per wait and a sticky result until the next start.
// Assumes: init/done are asynchronous to clk; bit source obeys valid/ready.
module cfg_serial_loader
    import cfgs_pkg::*;
#(
    parameter int POLL_CYCLES      = 125000,
    parameter int POLL_LIMIT       = 3,
    parameter int STEP_CYCLES      = 4,
    parameter int SYNC_STAGES      = 2,
    parameter bit PROG_ACTIVE_HIGH = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output logic       busy_o,
    output logic       done_ok_o,
    output logic [1:0] err_code_o,
    input  logic       bit_valid_i,
    input  logic       bit_data_i,
    input  logic       bit_last_i,
    output logic       bit_ready_o,
    output logic       cfg_prog_o,
    output logic       cfg_clk_o,
    output logic       cfg_data_o,
    input  logic       cfg_init_i,
    input  logic       cfg_done_i
);
    cfg_state_t state_q, state_nx;
    cfg_err_t   err_q, err_nx;
    logic       ok_q, ok_nx;
    logic [1:0] stat_s;
    logic       init_s, done_s;
    logic       tmr_run, tmr_clr, tmr_exp;
    logic       stream_end;

    cfgs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cfg_done_i, cfg_init_i}),
        .sync_o  (stat_s)
    );
    assign init_s = stat_s[0];
    assign done_s = stat_s[1];

    assign tmr_run = (state_q == ST_PROG) || (state_q == ST_INIT_WAIT) ||
                     (state_q == ST_DONE_WAIT);
    assign tmr_clr = (state_nx != state_q);

    cfgs_poll_timer #(.POLL_CYCLES(POLL_CYCLES), .POLL_LIMIT(POLL_LIMIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tmr_run),
        .clr_i     (tmr_clr),
        .expired_o (tmr_exp)
    );

    cfgs_bit_shifter #(.STEP_CYCLES(STEP_CYCLES)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (state_q == ST_SHIFT),
        .bit_valid_i  (bit_valid_i),
        .bit_data_i   (bit_data_i),
        .bit_last_i   (bit_last_i),
        .bit_ready_o  (bit_ready_o),
        .pin_clk_o    (cfg_clk_o),
        .pin_data_o   (cfg_data_o),
        .stream_end_o (stream_end)
    );

    // Next-state and result selection for the load sequence.
    always_comb begin
        state_nx = state_q;
        err_nx   = err_q;
        ok_nx    = ok_q;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                state_nx = ST_PROG;
                err_nx   = ERR_NONE;
                ok_nx    = 1'b0;
            end
            ST_PROG: if (!init_s) begin
                state_nx = ST_INIT_WAIT;
            end else if (tmr_exp) begin
                state_nx = ST_IDLE;
                err_nx   = ERR_INIT_LOW;
            end
            ST_INIT_WAIT: if (init_s) begin
                state_nx = ST_SHIFT;
            end else if (tmr_exp) begin
                state_nx = ST_IDLE;
                err_nx   = ERR_INIT_HIGH;
            end
            ST_SHIFT: if (stream_end) begin
                state_nx = ST_DONE_WAIT;
            end
            ST_DONE_WAIT: if (done_s) begin
                state_nx = ST_IDLE;
                ok_nx    = 1'b1;
            end else if (tmr_exp) begin
                state_nx = ST_IDLE;
                err_nx   = ERR_DONE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Register the sequence state and the sticky result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= ERR_NONE;
            ok_q    <= 1'b0;
        end else begin
            state_q <= state_nx;
            err_q   <= err_nx;
            ok_q    <= ok_nx;
        end
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign done_ok_o  = ok_q;
    assign err_code_o = err_q;
    assign cfg_prog_o = (state_q == ST_PROG) ? PROG_ACTIVE_HIGH : !PROG_ACTIVE_HIGH;
endmodule

// File: rtl/cfgs_checker.sv
// Port-level properties of the serial configuration loader, bound to
// every instance of the top module.
// Assumes: outputs are registered-state decodes and settle after each edge.
module cfgs_checker #(
    parameter bit PROG_ACTIVE_HIGH = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       done_ok_o,
    input logic [1:0] err_code_o,
    input logic       bit_ready_o,
    input logic       cfg_prog_o,
    input logic       cfg_clk_o,
    input logic       cfg_data_o
);
    logic prog_on;
    assign prog_on = (cfg_prog_o == PROG_ACTIVE_HIGH);

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cfg_clk_o && cfg_data_o && !prog_on && !bit_ready_o)); // R1
    AST_PROG_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_on |-> (busy_o && !bit_ready_o && cfg_clk_o)); // R2
    AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ready_o |-> (busy_o && cfg_clk_o && cfg_data_o)); // R6
    AST_DATA_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_clk_o) |-> $stable(cfg_data_o)); // R5
    AST_DATA_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_clk_o) |-> cfg_data_o); // R5
    AST_OK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok_o |-> (err_code_o == 2'd0)); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> ($stable(err_code_o) && $stable(done_ok_o))); // R8
endmodule

bind cfg_serial_loader cfgs_checker #(.PROG_ACTIVE_HIGH(PROG_ACTIVE_HIGH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_ok_o   (done_ok_o),
    .err_code_o  (err_code_o),
    .bit_ready_o (bit_ready_o),
    .cfg_prog_o  (cfg_prog_o),
    .cfg_clk_o   (cfg_clk_o),
    .cfg_data_o  (cfg_data_o)
);

// File: tb/tb_cfg_serial_loader.sv
// Bench: behavioural cycle model compared on every clock, plus probes.
module tb_cfg_serial_loader;
    localparam int P    = 20;
    localparam int LIM  = 3;
    localparam int STEP = 2;
    localparam int TMO  = (LIM + 1) * P;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, bvalid = 1'b0, bdata = 1'b0, blast = 1'b0;
    logic init_in = 1'b1, done_in = 1'b0;
    logic busy, ok, ready, prog, cclk, cdata;
    logic [1:0] err;
    logic busy_h, ok_h, ready_h, prog_h, cclk_h, cdata_h;
    logic [1:0] err_h;

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    int clk_rises = 0;

    always #4 clk = ~clk;

    cfg_serial_loader #(.POLL_CYCLES(P), .POLL_LIMIT(LIM), .STEP_CYCLES(STEP),
                        .PROG_ACTIVE_HIGH(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_ok_o(ok),
        .err_code_o(err), .bit_valid_i(bvalid), .bit_data_i(bdata), .bit_last_i(blast),
        .bit_ready_o(ready), .cfg_prog_o(prog), .cfg_clk_o(cclk), .cfg_data_o(cdata),
        .cfg_init_i(init_in), .cfg_done_i(done_in));

    cfg_serial_loader #(.POLL_CYCLES(P), .POLL_LIMIT(LIM), .STEP_CYCLES(STEP),
                        .PROG_ACTIVE_HIGH(1'b1)) dut_hi (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy_h), .done_ok_o(ok_h),
        .err_code_o(err_h), .bit_valid_i(bvalid), .bit_data_i(bdata), .bit_last_i(blast),
        .bit_ready_o(ready_h), .cfg_prog_o(prog_h), .cfg_clk_o(cclk_h), .cfg_data_o(cdata_h),
        .cfg_init_i(init_in), .cfg_done_i(done_in));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: 0 idle, 1 program, 2 init-rise wait, 3 shift, 4 done wait.
    int m_st = 0, m_t = 0, m_err = 0, m_ok = 0;
    int i1 = 0, i2 = 0, d1 = 0, d2 = 0;
    int m_act = 0, m_ph = 0, m_pc = 0, m_bit = 1, m_last = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_t = 0; m_err = 0; m_ok = 0;
            i1 = 0; i2 = 0; d1 = 0; d2 = 0; m_act = 0; m_ph = 0; m_pc = 0;
        end else begin
            case (m_st)
                0: if (start) begin m_st = 1; m_err = 0; m_ok = 0; m_t = 0; end
                1: if (i2 == 0) begin m_st = 2; m_t = 0; end
                   else if (m_t == TMO - 1) begin m_st = 0; m_err = 1; end
                   else m_t++;
                2: if (i2 == 1) m_st = 3;
                   else if (m_t == TMO - 1) begin m_st = 0; m_err = 2; end
                   else m_t++;
                3: if (m_act == 0) begin
                       if (bvalid) begin
                           m_act = 1; m_ph = 0; m_pc = 0; m_bit = bdata; m_last = blast;
                       end
                   end else if (m_pc == STEP - 1) begin
                       m_pc = 0;
                       if (m_ph == 3) begin
                           m_act = 0;
                           if (m_last) begin m_st = 4; m_t = 0; end
                       end else m_ph++;
                   end else m_pc++;
                4: if (d2 == 1) begin m_st = 0; m_ok = 1; end
                   else if (m_t == TMO - 1) begin m_st = 0; m_err = 3; end
                   else m_t++;
                default: m_st = 0;
            endcase
            i2 = i1; i1 = init_in; d2 = d1; d1 = done_in;
        end
    end

    // Compare every output with the model shortly after each edge.
    logic cclk_prev = 1'b1;
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            check("R2/R3/R10 prog", prog, (m_st == 1) ? 0 : 1);
            check("R5 cfg_clk", cclk, (m_act && m_ph < 2) ? 0 : 1);
            check("R5 cfg_data", cdata, (m_act && (m_ph == 1 || m_ph == 2)) ? m_bit : 1);
            check("R6 ready", ready, (m_st == 3 && !m_act) ? 1 : 0);
            check("R1 busy", busy, (m_st != 0) ? 1 : 0);
            check("R7 err", err, m_err);
            check("R7 ok", ok, m_ok);
            check("R9 polarity", prog_h, !prog);
            if (cclk && !cclk_prev) clk_rises++;
        end
        cclk_prev = cclk;
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic send_bit(input logic b, input logic l, input int gap);
        repeat (gap) @(negedge clk);
        bvalid = 1'b1; bdata = b; blast = l;
        while (!ready) @(negedge clk);
        @(negedge clk);
        bvalid = 1'b0; blast = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] pat;
        int n;
        pat = 8'b1011_0010;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset/idle state
        check("R1 idle prog", prog, 1);
        check("R1 idle clk", cclk, 1);
        check("R1 idle data", cdata, 1);
        check("R1 idle busy", busy, 0);
        check("R1 idle ready", ready, 0);

        // Run A: init never falls -> error 1 after exact timeout (R2, R4)
        pulse_start();
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R4 wait length", n, TMO);
        check("R2 error code", err, 1);
        repeat (20) @(negedge clk);
        check("R8 hold err", err, 1);

        // Run B: full success with stalls, stray start, valid held early (R5..R8, R10)
        bvalid = 1'b1; bdata = 1'b0;
        pulse_start();
        check("R8 err cleared", err, 0);
        repeat (5) @(negedge clk);
        check("R6 no ready in program phase", ready, 0);
        init_in = 1'b0;
        @(posedge clk); @(posedge clk); #2;
        check("R10 still asserted", prog, 0);
        @(posedge clk); #2;
        check("R10 released on third edge", prog, 1);
        bvalid = 1'b0;
        pulse_start();
        repeat (4) @(negedge clk);
        init_in = 1'b1;
        clk_rises = 0;
        for (int k = 7; k >= 0; k--) send_bit(pat[k], (k == 0), k % 3);
        while (busy && cdata !== 1'bx && ready === 1'b0 && clk_rises < 8) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R5 clock pulses", clk_rises, 8);
        check("R7 still busy in done wait", busy, 1);
        done_in = 1'b1;
        while (busy) @(negedge clk);
        check("R7 ok", ok, 1);
        check("R7 err zero", err, 0);
        repeat (15) @(negedge clk);
        check("R8 hold ok", ok, 1);
        done_in = 1'b0;

        // Run C: init stays low -> error 2 (R3)
        pulse_start();
        repeat (3) @(negedge clk);
        init_in = 1'b0;
        while (busy) @(negedge clk);
        check("R3 error code", err, 2);
        init_in = 1'b1;
        repeat (5) @(negedge clk);

        // Run D: done never rises -> error 3 (R7)
        pulse_start();
        repeat (3) @(negedge clk);
        init_in = 1'b0;
        repeat (6) @(negedge clk);
        init_in = 1'b1;
        send_bit(1'b0, 1'b0, 0);
        send_bit(1'b1, 1'b1, 2);
        while (busy) @(negedge clk);
        check("R7 done timeout code", err, 3);
        check("R7 ok low", ok, 0);
        check("R9 idle level high-polarity", prog_h, 0);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule